// File: doc/BRIEF.md
# Reset and Wake Event Controller

This block sits beside the bus interface of a network controller. It turns an active-low reset pin, which may change at any moment relative to the clock, into two internal reset levels. The first is a hardware reset for the controller core. It is only raised while the power-good input is high. The second is a global output-disable that isolates the bus-side drivers whenever the reset pin is low, whatever the state of power-good. While the reset pin is low and power-good is high, the block also enables a NAND-tree pin test. In that test the bidirectional bus pins act purely as inputs.

The block also drives the open-drain wake event pin. Three product terms of wake sources feed it: stored wake status with its enable, an enable override with a magic-packet match, and the same override with a link-change detection. The wake logic has no clock and no reset. It keeps working during reset and during pin isolation.

A saturating counter measures each qualified reset pulse. A pulse shorter than the minimum length sets a reset-too-short flag. The flag stays set until a reset of valid length has been released. The bus request driver is turned off while outputs are isolated and while power-management mode is active.

Top module: `rstwake_ctrl`

## Requirements
- R1: With `rst_n_raw` low and `pwr_good` high, `hw_reset` and `out_disable` are 1 at once, without waiting for a clock edge.
- R2: After `rst_n_raw` rises, `hw_reset` and `out_disable` stay 1 through the first rising clock edge and fall to 0 at the second rising edge.
- R3: With `pwr_good` low, a low `rst_n_raw` raises `out_disable` at once, while `hw_reset` stays 0 and the wake pin keeps working.
- R4: `nand_test_en` is 1 exactly while `rst_n_raw` is low and `pwr_good` is high, and 0 in all other cases.
- R5: `wake_oe` is 1 when (`wk_status` and `wk_enable`), or (`wk_override` and `magic_hit`), or (`wk_override` and `link_chg`) holds. Otherwise it is 0. `wake_drv` is always 0, so the pin is pulled low when enabled and floats when not enabled.
- R6: `wake_oe` follows its inputs combinationally while `hw_reset` is 1.
- R7: A reset pulse that lasts fewer than `MIN_RST_CLKS` (default 30) clock periods with `pwr_good` high sets `rst_short_err` within 4 rising edges after `rst_n_raw` rises.
- R8: Once set, `rst_short_err` stays 1, including across later short pulses. It is cleared only by the release of a reset pulse of at least `MIN_RST_CLKS` clocks.
- R9: `req_oe` is 1 only when `out_disable` is 0 and `pm_mode` is 0.
- R10: A low `pwr_good` sampled at a rising edge clears `rst_short_err` and the pulse counter from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n_raw | input | 1 | Raw reset pin, active low, asynchronous |
| pwr_good | input | 1 | Power-good qualifier for the reset pin |
| pm_mode | input | 1 | Power-management mode is active |
| wk_status | input | 1 | Stored wake status |
| wk_enable | input | 1 | Wake enable |
| wk_override | input | 1 | Wake enable override |
| magic_hit | input | 1 | Magic-packet match detected |
| link_chg | input | 1 | Link state change detected |
| hw_reset | output | 1 | Internal hardware reset, active high |
| out_disable | output | 1 | Global disable of the bus-side outputs |
| nand_test_en | output | 1 | NAND-tree pin test enabled |
| req_oe | output | 1 | Output enable for the bus request driver |
| wake_oe | output | 1 | Wake pin output enable |
| wake_drv | output | 1 | Wake pin data value (constant low) |
| rst_short_err | output | 1 | Reset pulse was shorter than the minimum |

## Verification
Each result has its own delay. The assertion of `hw_reset`, `out_disable` and `nand_test_en` is due with no clock edge at all, so the bench changes the pin and samples 1 ns later. Reset release is due at the second rising edge. The bench therefore checks on the falling edge after the first rising edge (still asserted) and again after the second (released). `rst_short_err` passes through two synchronizer flops and an edge detector, so it is sampled five falling edges after release, which leaves a margin beyond its three-edge latency. The wake and request outputs are combinational and are checked 1 ns after each input change.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

  // Minimum qualified reset length, in clock periods
  localparam int DEF_MIN_RST_CLKS = 30;
  // Flops in each reset-release synchronizer
  localparam int DEF_SYNC_STAGES  = 2;

  // Wake pin product terms
  function automatic logic wake_terms(input logic sts, input logic en,
                                      input logic ovr, input logic mp,
                                      input logic lc);
    return (sts & en) | (ovr & mp) | (ovr & lc);
  endfunction

endpackage

// File: rtl/rstwake_rst_sync.sv
// Asynchronous-assert, synchronous-release reset conditioner.
module rstwake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '1;
    else         chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/rstwake_lvl_sync.sv
// Plain level synchronizer, no reset.
module rstwake_lvl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rstwake_pulse_meter.sv
// Measures synchronized reset pulses. Flags pulses shorter than MIN_CLKS.
module rstwake_pulse_meter #(
  parameter int MIN_CLKS = 30
) (
  input  logic clk,
  input  logic clr,
  input  logic act,
  output logic short_err
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CLKS);

  logic [CW-1:0] cnt;
  logic          act_d;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt       <= '0;
      act_d     <= 1'b0;
      short_err <= 1'b0;
    end else begin
      act_d <= act;
      if (act) begin
        if (cnt != LIMIT) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
      if (act_d && !act) short_err <= (cnt != LIMIT);
    end
  end
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
  import rstwake_pkg::*;
#(
  parameter int MIN_RST_CLKS = DEF_MIN_RST_CLKS,
  parameter int SYNC_STAGES  = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n_raw,
  input  logic pwr_good,
  input  logic pm_mode,
  input  logic wk_status,
  input  logic wk_enable,
  input  logic wk_override,
  input  logic magic_hit,
  input  logic link_chg,
  output logic hw_reset,
  output logic out_disable,
  output logic nand_test_en,
  output logic req_oe,
  output logic wake_oe,
  output logic wake_drv,
  output logic rst_short_err
);
  logic full_rst_n;
  logic qual_act;
  logic qual_act_s;

  // Core reset counts only when power is good
  assign full_rst_n = rst_n_raw | ~pwr_good;
  assign qual_act   = ~rst_n_raw & pwr_good;

  rstwake_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk    (clk),
    .arst_n (full_rst_n),
    .rst_o  (hw_reset)
  );

  rstwake_rst_sync #(.STAGES(SYNC_STAGES)) u_iso_sync (
    .clk    (clk),
    .arst_n (rst_n_raw),
    .rst_o  (out_disable)
  );

  rstwake_lvl_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk (clk),
    .d_i (qual_act),
    .q_o (qual_act_s)
  );

  rstwake_pulse_meter #(.MIN_CLKS(MIN_RST_CLKS)) u_meter (
    .clk       (clk),
    .clr       (~pwr_good),
    .act       (qual_act_s),
    .short_err (rst_short_err)
  );

  assign nand_test_en = qual_act;
  assign req_oe       = ~out_disable & ~pm_mode;

  // Open-drain wake pin: no clock, no reset
  assign wake_oe  = wake_terms(wk_status, wk_enable, wk_override, magic_hit, link_chg);
  assign wake_drv = 1'b0;
endmodule

// File: rtl/rstwake_ctrl_chk.sv
module rstwake_ctrl_chk (
  input logic clk,
  input logic rst_n_raw,
  input logic pwr_good,
  input logic pm_mode,
  input logic wk_status,
  input logic wk_enable,
  input logic wk_override,
  input logic magic_hit,
  input logic link_chg,
  input logic hw_reset,
  input logic out_disable,
  input logic nand_test_en,
  input logic req_oe,
  input logic wake_oe,
  input logic rst_short_err
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_CORE_RST_ON: assert property (@(posedge clk) disable iff (!seen)
    (!rst_n_raw && pwr_good) |-> hw_reset); // R1
  AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!seen)
    (rst_n_raw && !$past(rst_n_raw) && pwr_good && $past(pwr_good)) |-> (hw_reset && out_disable)); // R2
  AST_ISO_ON: assert property (@(posedge clk) disable iff (!seen)
    (!rst_n_raw) |-> out_disable); // R3
  AST_CORE_FREE_PG: assert property (@(posedge clk) disable iff (!seen)
    (!pwr_good && $past(!pwr_good) && $past(!pwr_good, 2)) |-> !hw_reset); // R3
  AST_NAND_ISO: assert property (@(posedge clk) disable iff (!seen)
    nand_test_en |-> out_disable); // R4
  AST_WAKE_STS: assert property (@(posedge clk)
    (wk_status && wk_enable) |-> wake_oe); // R5
  AST_WAKE_OVR: assert property (@(posedge clk)
    (wk_override && (magic_hit || link_chg)) |-> wake_oe); // R5
  AST_WAKE_IDLE: assert property (@(posedge clk)
    (!(wk_status && wk_enable) && !wk_override) |-> !wake_oe); // R5
  AST_REQ_PM: assert property (@(posedge clk) disable iff (!seen)
    pm_mode |-> !req_oe); // R9
  AST_REQ_ISO: assert property (@(posedge clk) disable iff (!seen)
    out_disable |-> !req_oe); // R9
  AST_ERR_PG_CLR: assert property (@(posedge clk) disable iff (!seen)
    $past(!pwr_good) |-> !rst_short_err); // R10
endmodule

bind rstwake_ctrl rstwake_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n_raw     (rst_n_raw),
  .pwr_good      (pwr_good),
  .pm_mode       (pm_mode),
  .wk_status     (wk_status),
  .wk_enable     (wk_enable),
  .wk_override   (wk_override),
  .magic_hit     (magic_hit),
  .link_chg      (link_chg),
  .hw_reset      (hw_reset),
  .out_disable   (out_disable),
  .nand_test_en  (nand_test_en),
  .req_oe        (req_oe),
  .wake_oe       (wake_oe),
  .rst_short_err (rst_short_err)
);

// File: tb/rstwake_ctrl_test.sv
`timescale 1ns/1ps
module rstwake_ctrl_test;
  logic clk = 1'b0;
  logic rst_n_raw = 1'b0;
  logic pwr_good = 1'b0;
  logic pm_mode = 1'b0;
  logic wk_status = 1'b0, wk_enable = 1'b0, wk_override = 1'b0;
  logic magic_hit = 1'b0, link_chg = 1'b0;
  logic hw_reset, out_disable, nand_test_en, req_oe, wake_oe, wake_drv, rst_short_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstwake_ctrl uut (
    .clk(clk), .rst_n_raw(rst_n_raw), .pwr_good(pwr_good), .pm_mode(pm_mode),
    .wk_status(wk_status), .wk_enable(wk_enable), .wk_override(wk_override),
    .magic_hit(magic_hit), .link_chg(link_chg),
    .hw_reset(hw_reset), .out_disable(out_disable), .nand_test_en(nand_test_en),
    .req_oe(req_oe), .wake_oe(wake_oe), .wake_drv(wake_drv), .rst_short_err(rst_short_err)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int len);
    rst_n_raw = 1'b0;
    tick(len);
    rst_n_raw = 1'b1;
    tick(5);
  endtask

  task automatic t_reset_state();
    tick(3);
    check("R3 out_disable at power-up", out_disable, 1'b1);
    check("R3 hw_reset low with pg low", hw_reset, 1'b0);
    check("R4 nand off with pg low", nand_test_en, 1'b0);
    check("R9 req_oe off while isolated", req_oe, 1'b0);
    check("R5 wake idle", wake_oe, 1'b0);
    check("R10 err clear", rst_short_err, 1'b0);
  endtask

  task automatic t_assert_release();
    pwr_good = 1'b1;
    #1;
    check("R1 hw_reset async on pg rise", hw_reset, 1'b1);
    check("R4 nand on", nand_test_en, 1'b1);
    tick(40);
    rst_n_raw = 1'b1;
    #1;
    check("R4 nand off after release", nand_test_en, 1'b0);
    tick(1);
    check("R2 hw_reset held after 1 edge", hw_reset, 1'b1);
    check("R2 out_disable held after 1 edge", out_disable, 1'b1);
    tick(1);
    check("R2 hw_reset released after 2 edges", hw_reset, 1'b0);
    check("R2 out_disable released after 2 edges", out_disable, 1'b0);
    check("R9 req_oe on", req_oe, 1'b1);
    tick(3);
    check("R8 valid reset leaves err clear", rst_short_err, 1'b0);
    #3;
    rst_n_raw = 1'b0;
    #1;
    check("R1 hw_reset async mid-cycle", hw_reset, 1'b1);
    check("R1 out_disable async mid-cycle", out_disable, 1'b1);
    tick(35);
    rst_n_raw = 1'b1;
    tick(5);
  endtask

  task automatic t_pm();
    pm_mode = 1'b1;
    #1;
    check("R9 req_oe off in pm mode", req_oe, 1'b0);
    pm_mode = 1'b0;
    #1;
    check("R9 req_oe back on", req_oe, 1'b1);
  endtask

  task automatic t_wake();
    for (int v = 0; v < 32; v++) begin
      logic e;
      {wk_status, wk_enable, wk_override, magic_hit, link_chg} = 5'(v);
      e = (v[4] & v[3]) | (v[2] & v[1]) | (v[2] & v[0]);
      #1;
      check("R5 wake term", wake_oe, e);
      check("R5 wake drive low", wake_drv, 1'b0);
    end
    {wk_status, wk_enable, wk_override, magic_hit, link_chg} = 5'b0;
  endtask

  task automatic t_wake_in_reset();
    rst_n_raw = 1'b0;
    tick(2);
    check("R6 in reset", hw_reset, 1'b1);
    wk_override = 1'b1; link_chg = 1'b1;
    #1;
    check("R6 wake via link during reset", wake_oe, 1'b1);
    link_chg = 1'b0;
    #1;
    check("R6 wake idle during reset", wake_oe, 1'b0);
    magic_hit = 1'b1;
    #1;
    check("R6 wake via magic during reset", wake_oe, 1'b1);
    wk_override = 1'b0; magic_hit = 1'b0;
    tick(35);
    rst_n_raw = 1'b1;
    tick(5);
  endtask

  task automatic t_isolation();
    pwr_good = 1'b0;
    tick(3);
    rst_n_raw = 1'b0;
    #1;
    check("R3 out_disable async with pg low", out_disable, 1'b1);
    check("R4 nand off with pg low", nand_test_en, 1'b0);
    tick(3);
    check("R3 hw_reset stays low", hw_reset, 1'b0);
    wk_status = 1'b1; wk_enable = 1'b1;
    #1;
    check("R3 wake works while isolated", wake_oe, 1'b1);
    wk_status = 1'b0; wk_enable = 1'b0;
    rst_n_raw = 1'b1;
    tick(3);
    check("R3 isolation released", out_disable, 1'b0);
    pwr_good = 1'b1;
    tick(2);
  endtask

  task automatic t_short();
    pulse(20);
    check("R7 short pulse flagged", rst_short_err, 1'b1);
    tick(40);
    check("R8 flag holds", rst_short_err, 1'b1);
    pulse(10);
    check("R8 flag holds after second short", rst_short_err, 1'b1);
    pulse(35);
    check("R8 valid reset clears flag", rst_short_err, 1'b0);
  endtask

  task automatic t_pg_clear();
    pulse(12);
    check("R7 flag set before pg drop", rst_short_err, 1'b1);
    pwr_good = 1'b0;
    tick(2);
    check("R10 pg low clears flag", rst_short_err, 1'b0);
    pwr_good = 1'b1;
    tick(2);
    check("R10 flag stays clear after pg return", rst_short_err, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_assert_release();
    t_pm();
    t_wake();
    t_wake_in_reset();
    t_isolation();
    t_short();
    t_pg_clear();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule